// File: doc/BRIEF.md
# Digital Loss-of-Signal Detector

This block watches a stream of decoded receive bits, one per bit period, and keeps a single status flag that reports a digital loss of signal. A bit counts only in a cycle where its valid strobe is high. The flag sets once a long unbroken run of zeros has been seen. Once set, the flag does not drop on the first mark that comes back. It clears only when the average pulse density over a whole observation window is above one third. Setting on a run of zeros and clearing on density gives the flag hysteresis.

The run length and the window length are the same programmed value, N. N comes from the `run_len` input and is clamped into the range given by the parameters `LEN_MIN` and `LEN_MAX` (100 and 250 by default). The flag is a plain registered output, ready to be placed in a status register by the surrounding logic.

Top module: `dlos_detect`

## Requirements
- R1: After reset the flag `los` is 0, and the zero-run count, the window bit count and the window mark count are all zero.
- R2: While `los` is 0, `los` becomes 1 on the clock edge that takes in the valid bit holding the N-th consecutive zero, where N is the effective length. It stays 0 after N-1 consecutive zeros.
- R3: While `los` is 0, a valid bit of value 1 restarts the zero run, so a zero run must be N long after the last mark.
- R4: The effective length N is `run_len` clamped to the range LEN_MIN to LEN_MAX: a value below LEN_MIN acts as LEN_MIN, and a value above LEN_MAX acts as LEN_MAX.
- R5: While `los` is 1, valid bits are grouped into windows of N bits. The first window starts with the first valid bit after the flag sets. On the edge that takes in the last bit of a window, `los` clears if 3 × (number of ones in the window) > N.
- R6: If a window ends without meeting the density test, `los` stays 1 and a new window starts with the next valid bit.
- R7: A cycle with `bit_valid` low changes no counter and does not change `los`, whatever the value of `bit_in`.
- R8: Counters are bounded and cannot wrap. After a zero run many times longer than N, a single window that meets the density test still clears `los`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_valid | input | 1 | Strobe: `bit_in` holds a bit this cycle |
| bit_in | input | 1 | Decoded receive bit, 1 = mark |
| run_len | input | LEN_W | Programmed run and window length, before clamping |
| los | output | 1 | Loss-of-signal flag, 1 while the loss is active |

## Verification
The assertions assume that `run_len` does not change while a zero run or a window is in progress. The stimulus changes it only directly after a reset. They also assume that `bit_in` is sampled only when `bit_valid` is high. The stimulus therefore drives the opposite bit value during idle cycles, to show that the bit has no effect. The bench uses a small configuration (4 to 12) and sweeps every effective length. For each length it tries every count of ones in a window, from 0 up to N. The expected result is worked out as 3k > N, with k the count of ones.

// File: rtl/dlos_pkg.sv
package dlos_pkg;
   // Clamp a requested length into [lo, hi].
   function automatic int unsigned dlos_clamp(input int unsigned v,
                                              input int unsigned lo,
                                              input int unsigned hi);
      if (v < lo)      return lo;
      else if (v > hi) return hi;
      else             return v;
   endfunction
endpackage

// File: rtl/dlos_zero_run.sv
module dlos_zero_run #(
   parameter int LEN_W   = 8,
   parameter int LEN_MAX = 250
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_valid,
   input  logic             bit_in,
   input  logic             los,
   input  logic [LEN_W-1:0] eff_len,
   output logic             run_hit
);
   localparam logic [LEN_W-1:0] CNT_CAP = LEN_W'(LEN_MAX);

   logic [LEN_W-1:0] zcnt;
   logic [LEN_W:0]   zcnt_inc;

   assign zcnt_inc = {1'b0, zcnt} + 1'b1;
   assign run_hit  = bit_valid && !bit_in && !los && (zcnt_inc >= {1'b0, eff_len});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 zcnt <= '0;
      else if (los)               zcnt <= '0;
      else if (bit_valid) begin
         if (bit_in)              zcnt <= '0;
         else if (zcnt != CNT_CAP) zcnt <= zcnt_inc[LEN_W-1:0];
      end
   end

   // R8
   zrun_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      zcnt <= CNT_CAP);

   // R7
   zrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(zcnt) |-> ($past(bit_valid) || $past(los)));
endmodule

// File: rtl/dlos_density_win.sv
module dlos_density_win #(
   parameter int LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_valid,
   input  logic             bit_in,
   input  logic             los,
   input  logic [LEN_W-1:0] eff_len,
   output logic             win_clear
);
   localparam int PW = LEN_W + 2;

   logic [LEN_W-1:0] win_cnt, ones_cnt;
   logic [LEN_W:0]   win_nxt, ones_nxt;
   logic [PW-1:0]    triple;
   logic             win_end;

   assign win_nxt   = {1'b0, win_cnt} + 1'b1;
   assign ones_nxt  = {1'b0, ones_cnt} + {{LEN_W{1'b0}}, bit_in};
   assign triple    = PW'(ones_nxt) * PW'(3);
   assign win_end   = los && bit_valid && (win_nxt >= {1'b0, eff_len});
   assign win_clear = win_end && (triple > PW'(eff_len));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_cnt  <= '0;
         ones_cnt <= '0;
      end else if (!los || win_end) begin
         win_cnt  <= '0;
         ones_cnt <= '0;
      end else if (bit_valid) begin
         win_cnt  <= win_nxt[LEN_W-1:0];
         ones_cnt <= ones_nxt[LEN_W-1:0];
      end
   end

   // R5
   ones_le_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ones_cnt <= win_cnt);

   // R8
   win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_cnt < eff_len);
endmodule

// File: rtl/dlos_detect.sv
module dlos_detect #(
   parameter int LEN_MIN   = 100,
   parameter int LEN_MAX   = 250,
   parameter int LEN_W     = 8,
   parameter bit CLAMP_LEN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_valid,
   input  logic             bit_in,
   input  logic [LEN_W-1:0] run_len,
   output logic             los
);
   import dlos_pkg::*;

   logic [LEN_W-1:0] eff_len;
   logic             run_hit, win_clear, los_q;

   generate
      if (LEN_MIN < 1 || LEN_MAX < LEN_MIN || LEN_MAX >= (1 << LEN_W)) begin : g_bad
         $error("dlos_detect: length parameters out of range");
      end
      if (CLAMP_LEN) begin : g_clamp
         assign eff_len = LEN_W'(dlos_clamp(32'(run_len), LEN_MIN, LEN_MAX));
      end else begin : g_pass
         assign eff_len = run_len;
      end
   endgenerate

   dlos_zero_run #(.LEN_W(LEN_W), .LEN_MAX(LEN_MAX)) u_run (
      .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
      .los(los_q), .eff_len(eff_len), .run_hit(run_hit));

   dlos_density_win #(.LEN_W(LEN_W)) u_win (
      .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
      .los(los_q), .eff_len(eff_len), .win_clear(win_clear));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  los_q <= 1'b0;
      else if (!los_q && run_hit)  los_q <= 1'b1;
      else if (los_q && win_clear) los_q <= 1'b0;
   end

   assign los = los_q;

   // R4
   len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !CLAMP_LEN || (eff_len >= LEN_W'(LEN_MIN) && eff_len <= LEN_W'(LEN_MAX)));

   // R2
   set_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(los_q) |-> $past(bit_valid && !bit_in));

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(los_q) |-> $past(bit_valid));
endmodule

// File: tb/tb_dlos_detect.sv
module tb_dlos_detect;
   localparam int CLK_PERIOD = 10;
   localparam int LMIN = 4;
   localparam int LMAX = 12;
   localparam int LW   = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bit_valid = 1'b0;
   logic          bit_in = 1'b0;
   logic [LW-1:0] run_len = LW'(LMIN);
   logic          los;
   int            n_chk = 0;
   int            n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dlos_detect #(.LEN_MIN(LMIN), .LEN_MAX(LMAX), .LEN_W(LW)) dut (
      .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
      .run_len(run_len), .los(los));

   task automatic chk(input logic got, input logic exp, input string tag);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: los=%0b expected %0b", tag, got, exp);
      end
   endtask

   task automatic do_reset(input int len);
      rst_n = 1'b0; bit_valid = 1'b0; bit_in = 1'b0;
      run_len = LW'(len);
      repeat (2) @(posedge clk);
      #1 rst_n = 1'b1;
   endtask

   task automatic send(input logic b);
      bit_valid = 1'b1; bit_in = b;
      @(posedge clk); #1;
      bit_valid = 1'b0; bit_in = ~b;
   endtask

   task automatic idle(input int n, input logic b);
      bit_in = b;
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: los=%0b expected finish", los);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      do_reset(LMIN);
      #1 chk(los, 1'b0, "R1 reset state");

      // R2, R3: set point and mark restart across every length
      for (int len = LMIN; len <= LMAX; len++) begin
         do_reset(len);
         chk(los, 1'b0, "R1 after reset");
         for (int i = 0; i < len - 1; i++) send(1'b0);
         send(1'b1);
         for (int i = 0; i < len - 1; i++) send(1'b0);
         chk(los, 1'b0, "R3 mark restarts zero run");
         send(1'b0);
         chk(los, 1'b1, "R2 set on N-th zero");
      end

      // R7: idle cycles with a mark on bit_in do not restart the run
      do_reset(6);
      for (int i = 0; i < 3; i++) send(1'b0);
      idle(7, 1'b1);
      send(1'b0); send(1'b0);
      chk(los, 1'b0, "R7 idle does not advance");
      send(1'b0);
      chk(los, 1'b1, "R7 idle with mark ignored");
      // in LOS: idle marks do not count toward the window
      idle(20, 1'b1);
      chk(los, 1'b1, "R7 idle keeps flag");
      for (int i = 0; i < 6; i++) send(1'b0);
      chk(los, 1'b1, "R7 idle marks not counted");

      // R4: clamp below and above
      do_reset(2);
      for (int i = 0; i < LMIN - 1; i++) send(1'b0);
      chk(los, 1'b0, "R4 low clamp not yet");
      send(1'b0);
      chk(los, 1'b1, "R4 low clamp set");
      do_reset(15);
      for (int i = 0; i < LMAX - 1; i++) send(1'b0);
      chk(los, 1'b0, "R4 high clamp not yet");
      send(1'b0);
      chk(los, 1'b1, "R4 high clamp set");

      // R5, R6: every count of ones per window, every length
      for (int len = LMIN; len <= LMAX; len++) begin
         do_reset(len);
         for (int k = 0; k <= len; k++) begin
            if (!los) for (int i = 0; i < len; i++) send(1'b0);
            for (int i = 0; i < len; i++) begin
               send(i < k);
               if (i < len - 1) chk(los, 1'b1, "R6 flag held mid-window");
            end
            chk(los, (3 * k > len) ? 1'b0 : 1'b1,
                (3 * k > len) ? "R5 density clears" : "R6 window restarts");
         end
      end

      // R8: very long zero run, then one qualifying window clears
      do_reset(LMAX);
      for (int i = 0; i < 20 * LMAX; i++) send(1'b0);
      chk(los, 1'b1, "R8 long zero run holds flag");
      for (int i = 0; i < LMAX; i++) send(i % 2 == 0);
      chk(los, 1'b0, "R8 clears after long run");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule